// File: doc/BRIEF.md
# DMA Page Register Bank

This block holds the upper address bits for the channels of one DMA controller. It has eight 8-bit page registers, which supply address bits 23:16, and eight 8-bit high-page registers, which supply address bits 31:24. Software reaches both sets through a small I/O-style port that carries byte or word accesses. A select input picks the page set or the high-page set, and a three-bit index picks the register. A word access to the page set covers two neighbouring registers, and the index wraps from the last register back to the first. Writing a page register always zeroes the high-page register with the same index, so software that only knows about 24-bit addressing still produces addresses below 16 MB.

The channel side is purely combinational. The controller presents a channel number, its current 16-bit word or byte address, and whether it runs as an 8-bit or a 16-bit controller. The bank returns the full 32-bit physical address. Channels do not map to registers in order: each channel reads a fixed, scattered register index.

Top module: `dma_page_bank`

## Requirements
- R1: A page write with io_size = 2'b01 (byte) and io_sel_hi = 0 stores io_wdata[7:0] in page register io_idx and clears the high-page register with the same index. No other register changes.
- R2: A page write with io_size = 2'b10 (word) stores io_wdata[7:0] at index i = io_idx and io_wdata[15:8] at index (i+1) mod 8, and clears both matching high-page registers. From index 7 the upper byte goes to index 0.
- R3: A read takes effect at the clock edge where io_rd is high, and io_rdata shows the result from the next cycle until the next read. A byte page read returns {8'h00, page[i]}.
- R4: A word page read returns page[(i+1) mod 8] in bits 15:8 and page[i] in bits 7:0.
- R5: A high-page byte write (io_sel_hi = 1, io_size = 2'b01) stores io_wdata[7:0] in high-page register io_idx and leaves every page register as it was. A high-page byte read returns {8'h00, highpage[i]}.
- R6: A high-page word access changes no register, and when read it returns 16'hFFFF.
- R7: Channel 0, 1, 2 and 3 (ch_sel) take page and high-page index 7, 3, 1 and 2 respectively.
- R8: With wide_mode = 0, xfer_addr = {highpage, page, cur_addr}.
- R9: With wide_mode = 1, xfer_addr = {highpage, page[7:1], cur_addr, 1'b0}. Page bit 0 is dropped and the current address is shifted left by one.
- R10: Reset clears io_rdata to 16'h0000 and leaves every page and high-page register unchanged.
- R11: An access with io_size = 2'b00 or 2'b11 changes no register, and when read it returns 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the read data only |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_sel_hi | input | 1 | 0 selects the page set, 1 selects the high-page set |
| io_size | input | 2 | Access size: 01 byte, 10 word, other values unsupported |
| io_idx | input | 3 | Register index |
| io_wdata | input | 16 | Write data; the upper byte is used by page word writes |
| io_rdata | output | 16 | Registered read data |
| ch_sel | input | 2 | Channel whose address is formed |
| wide_mode | input | 1 | 1 when the controller runs 16-bit transfers |
| cur_addr | input | 16 | Current channel address |
| xfer_addr | output | 32 | Physical transfer address |

## Verification
The hardest case to reach is the wrap of a word access at index 7. There, one strobe has to update registers 7 and 0 together, and it also has to clear the high-page bytes at both ends of the bank. The stimulus first loads every high-page register with a nonzero value. It then issues word writes at index 3 and at index 7, and reads back each byte and word one at a time, so that a missed clear or a wrong wrap shows up at the port. Registers survive reset, and the bench shows this by loading known values, pulsing reset in the middle of the run and reading everything back.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_QUAD = 2'b11
  } io_size_e;

  // Fixed channel-to-register scatter (R7)
  function automatic int unsigned chan_to_page(input logic [1:0] ch);
    case (ch)
      2'd0:    return 7;
      2'd1:    return 3;
      2'd2:    return 1;
      default: return 2;
    endcase
  endfunction

  // Index of the neighbour touched by a word access, with wrap
  function automatic int unsigned next_index(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/dma_page_regfile.sv
module dma_page_regfile #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      wr_pg_byte,
  input  logic                      wr_pg_word,
  input  logic                      wr_hp_byte,
  input  logic [IDX_W-1:0]          idx,
  input  logic [2*REG_W-1:0]        wdata,
  output logic [NUM_REGS*REG_W-1:0] pg_flat,
  output logic [NUM_REGS*REG_W-1:0] hp_flat
);
  import dma_page_pkg::*;

  logic [IDX_W-1:0] idx_nxt;
  always_comb idx_nxt = IDX_W'(next_index(int'(idx), NUM_REGS));

  // Storage is deliberately not reset: contents survive reset
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_entry
    logic hit_lo, hit_up, hit_hp;
    logic [REG_W-1:0] pg_q, hp_q;

    always_comb begin
      hit_lo = (wr_pg_byte | wr_pg_word) && (idx == IDX_W'(k));
      hit_up = wr_pg_word && (idx_nxt == IDX_W'(k));
      hit_hp = wr_hp_byte && (idx == IDX_W'(k));
    end

    always_ff @(posedge clk) begin
      if (hit_lo)      pg_q <= wdata[REG_W-1:0];
      else if (hit_up) pg_q <= wdata[2*REG_W-1:REG_W];

      if (hit_hp)               hp_q <= wdata[REG_W-1:0];
      else if (hit_lo | hit_up) hp_q <= '0;
    end

    assign pg_flat[k*REG_W +: REG_W] = pg_q;
    assign hp_flat[k*REG_W +: REG_W] = hp_q;
  end

endmodule

// File: rtl/dma_page_rdmux.sv
module dma_page_rdmux #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                      rd_pg_byte,
  input  logic                      rd_pg_word,
  input  logic                      rd_hp_byte,
  input  logic [IDX_W-1:0]          idx,
  input  logic [NUM_REGS*REG_W-1:0] pg_flat,
  input  logic [NUM_REGS*REG_W-1:0] hp_flat,
  output logic [2*REG_W-1:0]        rd_value
);
  import dma_page_pkg::*;

  logic [REG_W-1:0] pg_lo, pg_up, hp_lo;
  int unsigned      nxt;

  always_comb begin
    nxt   = next_index(int'(idx), NUM_REGS);
    pg_lo = pg_flat[int'(idx)*REG_W +: REG_W];
    pg_up = pg_flat[nxt*REG_W +: REG_W];
    hp_lo = hp_flat[int'(idx)*REG_W +: REG_W];
    if (rd_pg_byte)      rd_value = {{REG_W{1'b0}}, pg_lo};
    else if (rd_pg_word) rd_value = {pg_up, pg_lo};
    else if (rd_hp_byte) rd_value = {{REG_W{1'b0}}, hp_lo};
    else                 rd_value = '1;
  end

endmodule

// File: rtl/dma_page_addrgen.sv
module dma_page_addrgen #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned CUR_W    = 16,
  localparam int unsigned ADDR_W  = 2*REG_W + CUR_W
) (
  input  logic [NUM_REGS*REG_W-1:0] pg_flat,
  input  logic [NUM_REGS*REG_W-1:0] hp_flat,
  input  logic [1:0]                ch_sel,
  input  logic                      wide_mode,
  input  logic [CUR_W-1:0]          cur_addr,
  output logic [ADDR_W-1:0]         xfer_addr
);
  import dma_page_pkg::*;

  function automatic logic [ADDR_W-1:0] form_addr(
    input logic [REG_W-1:0] hp, input logic [REG_W-1:0] pg,
    input logic [CUR_W-1:0] cur, input logic wide);
    if (wide) return {hp, pg[REG_W-1:1], cur, 1'b0};
    return {hp, pg, cur};
  endfunction

  int unsigned      sel;
  logic [REG_W-1:0] pg_sel, hp_sel;

  always_comb begin
    sel       = chan_to_page(ch_sel);
    pg_sel    = pg_flat[sel*REG_W +: REG_W];
    hp_sel    = hp_flat[sel*REG_W +: REG_W];
    xfer_addr = form_addr(hp_sel, pg_sel, cur_addr, wide_mode);
  end

endmodule

// File: rtl/dma_page_bank.sv
module dma_page_bank #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned CUR_W    = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned ADDR_W  = 2*REG_W + CUR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic               io_sel_hi,
  input  logic [1:0]         io_size,
  input  logic [IDX_W-1:0]   io_idx,
  input  logic [2*REG_W-1:0] io_wdata,
  output logic [2*REG_W-1:0] io_rdata,
  input  logic [1:0]         ch_sel,
  input  logic               wide_mode,
  input  logic [CUR_W-1:0]   cur_addr,
  output logic [ADDR_W-1:0]  xfer_addr
);
  import dma_page_pkg::*;

  // Named decode events
  logic sz_byte, sz_word;
  logic wr_pg_byte, wr_pg_word, wr_hp_byte;
  logic rd_pg_byte, rd_pg_word, rd_hp_byte;
  logic [NUM_REGS*REG_W-1:0] pg_flat, hp_flat;
  logic [2*REG_W-1:0]        rd_value;

  always_comb begin
    sz_byte    = (io_size_e'(io_size) == SZ_BYTE);
    sz_word    = (io_size_e'(io_size) == SZ_WORD);
    wr_pg_byte = io_wr & ~io_sel_hi & sz_byte;
    wr_pg_word = io_wr & ~io_sel_hi & sz_word;
    wr_hp_byte = io_wr &  io_sel_hi & sz_byte;
    rd_pg_byte = ~io_sel_hi & sz_byte;
    rd_pg_word = ~io_sel_hi & sz_word;
    rd_hp_byte =  io_sel_hi & sz_byte;
  end

  dma_page_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) regs_i (
    .clk        (clk),
    .wr_pg_byte (wr_pg_byte),
    .wr_pg_word (wr_pg_word),
    .wr_hp_byte (wr_hp_byte),
    .idx        (io_idx),
    .wdata      (io_wdata),
    .pg_flat    (pg_flat),
    .hp_flat    (hp_flat)
  );

  dma_page_rdmux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) rdmux_i (
    .rd_pg_byte (rd_pg_byte),
    .rd_pg_word (rd_pg_word),
    .rd_hp_byte (rd_hp_byte),
    .idx        (io_idx),
    .pg_flat    (pg_flat),
    .hp_flat    (hp_flat),
    .rd_value   (rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_value;
  end

  dma_page_addrgen #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .CUR_W(CUR_W)) addr_i (
    .pg_flat   (pg_flat),
    .hp_flat   (hp_flat),
    .ch_sel    (ch_sel),
    .wide_mode (wide_mode),
    .cur_addr  (cur_addr),
    .xfer_addr (xfer_addr)
  );

endmodule

// File: rtl/dma_page_bank_chk.sv
module dma_page_bank_chk #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned CUR_W    = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned ADDR_W  = 2*REG_W + CUR_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      io_wr,
  input logic                      io_rd,
  input logic                      io_sel_hi,
  input logic [1:0]                io_size,
  input logic [IDX_W-1:0]          io_idx,
  input logic [2*REG_W-1:0]        io_wdata,
  input logic [2*REG_W-1:0]        io_rdata,
  input logic                      wide_mode,
  input logic [CUR_W-1:0]          cur_addr,
  input logic [ADDR_W-1:0]         xfer_addr,
  input logic [NUM_REGS*REG_W-1:0] pg_flat,
  input logic [NUM_REGS*REG_W-1:0] hp_flat
);
  logic bad_sz, pg_wr, word_pg_wr;
  int unsigned nxt;
  always_comb begin
    bad_sz     = (io_size == 2'b00) || (io_size == 2'b11);
    pg_wr      = io_wr && !io_sel_hi && (io_size == 2'b01 || io_size == 2'b10);
    word_pg_wr = io_wr && !io_sel_hi && (io_size == 2'b10);
    nxt        = (int'(io_idx) + 1 >= NUM_REGS) ? 0 : int'(io_idx) + 1;
  end

  assert_pg_low_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pg_wr |=> (pg_flat[$past(int'(io_idx))*REG_W +: REG_W] == $past(io_wdata[REG_W-1:0]))
           && (hp_flat[$past(int'(io_idx))*REG_W +: REG_W] == '0));

  assert_word_spill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_pg_wr |=> (pg_flat[$past(nxt)*REG_W +: REG_W] == $past(io_wdata[2*REG_W-1:REG_W]))
                && (hp_flat[$past(nxt)*REG_W +: REG_W] == '0));

  assert_hp_keeps_pages_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel_hi) |=> $stable(pg_flat));

  assert_hp_word_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_sel_hi && io_size == 2'b10) |=> $stable(hp_flat));

  assert_bad_size_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && bad_sz) |=> ($stable(pg_flat) && $stable(hp_flat)));

  assert_bad_size_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && bad_sz) |=> (io_rdata == '1));

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  assert_narrow_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> (xfer_addr[CUR_W-1:0] == cur_addr));

  assert_wide_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode |-> (xfer_addr[CUR_W:0] == {cur_addr, 1'b0}));

endmodule

bind dma_page_bank dma_page_bank_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .CUR_W(CUR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_sel_hi(io_sel_hi),
  .io_size(io_size), .io_idx(io_idx), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .wide_mode(wide_mode), .cur_addr(cur_addr), .xfer_addr(xfer_addr),
  .pg_flat(pg_flat), .hp_flat(hp_flat)
);

// File: tb/dma_page_bank_tb.sv
module dma_page_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        io_wr = 0, io_rd = 0, io_sel_hi = 0;
  logic [1:0]  io_size = 0;
  logic [2:0]  io_idx = 0;
  logic [15:0] io_wdata = 0;
  logic [15:0] io_rdata;
  logic [1:0]  ch_sel = 0;
  logic        wide_mode = 0;
  logic [15:0] cur_addr = 0;
  logic [31:0] xfer_addr;

  int n_checks = 0, n_fail = 0;
  logic [7:0] m_pg [8];
  logic [7:0] m_hp [8];
  int chan_map [4] = '{7, 3, 1, 2};

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_page_bank dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_sel_hi(io_sel_hi),
    .io_size(io_size), .io_idx(io_idx), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ch_sel(ch_sel), .wide_mode(wide_mode), .cur_addr(cur_addr), .xfer_addr(xfer_addr)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic hi, input logic [2:0] idx, input logic [1:0] sz, input logic [15:0] d);
    @(negedge clk);
    io_wr = 1; io_sel_hi = hi; io_idx = idx; io_size = sz; io_wdata = d;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic do_rd(input logic hi, input logic [2:0] idx, input logic [1:0] sz, output logic [15:0] d);
    @(negedge clk);
    io_rd = 1; io_sel_hi = hi; io_idx = idx; io_size = sz;
    @(negedge clk);
    io_rd = 0;
    d = io_rdata;
  endtask

  // model updates, written from the requirements
  task automatic pg_byte(input int i, input logic [7:0] v);
    do_wr(0, 3'(i), 2'b01, {8'hA5, v});
    m_pg[i] = v; m_hp[i] = 8'h00;
  endtask

  task automatic hp_byte(input int i, input logic [7:0] v);
    do_wr(1, 3'(i), 2'b01, {8'h5A, v});
    m_hp[i] = v;
  endtask

  task automatic t_reset_state;
    check("R10 rdata after reset", {16'h0, io_rdata}, 32'h0);
  endtask

  task automatic t_byte_access;
    logic [15:0] d;
    for (int i = 0; i < 8; i++) hp_byte(i, 8'hE0 + 8'(i));
    for (int i = 0; i < 8; i++) pg_byte(i, 8'h11 * 8'(i) + 8'h03);
    for (int i = 0; i < 8; i++) begin
      do_rd(0, 3'(i), 2'b01, d);
      check("R3 byte page read", {16'h0, d}, {24'h0, m_pg[i]});
    end
    do_rd(1, 3'd5, 2'b01, d);
    check("R1 page write clears high page", {16'h0, d}, 32'h0);
  endtask

  task automatic t_word_access;
    logic [15:0] d;
    for (int i = 0; i < 8; i++) hp_byte(i, 8'hC0 + 8'(i));
    do_wr(0, 3'd3, 2'b10, 16'hBEEF);
    m_pg[3] = 8'hEF; m_pg[4] = 8'hBE; m_hp[3] = 0; m_hp[4] = 0;
    do_wr(0, 3'd7, 2'b10, 16'h1234);
    m_pg[7] = 8'h34; m_pg[0] = 8'h12; m_hp[7] = 0; m_hp[0] = 0;
    do_rd(0, 3'd4, 2'b01, d);
    check("R2 word upper byte", {16'h0, d}, 32'h00BE);
    do_rd(0, 3'd0, 2'b01, d);
    check("R2 word wrap to index 0", {16'h0, d}, 32'h0012);
    for (int i = 0; i < 8; i++) begin
      do_rd(1, 3'(i), 2'b01, d);
      check("R2 high page after word write", {16'h0, d}, {24'h0, m_hp[i]});
    end
    do_rd(0, 3'd7, 2'b10, d);
    check("R4 word read wrap", {16'h0, d}, {16'h0, m_pg[0], m_pg[7]});
    do_rd(0, 3'd2, 2'b10, d);
    check("R4 word read", {16'h0, d}, {16'h0, m_pg[3], m_pg[2]});
    @(negedge clk);
    check("R3 read data held", {16'h0, io_rdata}, {16'h0, m_pg[3], m_pg[2]});
  endtask

  task automatic t_high_page;
    logic [15:0] d;
    hp_byte(2, 8'h9C);
    do_rd(1, 3'd2, 2'b01, d);
    check("R5 high page read", {16'h0, d}, 32'h009C);
    do_rd(0, 3'd2, 2'b01, d);
    check("R5 page untouched by high write", {16'h0, d}, {24'h0, m_pg[2]});
    do_wr(1, 3'd2, 2'b10, 16'h7777);
    do_rd(1, 3'd2, 2'b01, d);
    check("R6 high word write ignored", {16'h0, d}, 32'h009C);
    do_rd(0, 3'd3, 2'b01, d);
    check("R6 page after high word write", {16'h0, d}, {24'h0, m_pg[3]});
    do_rd(1, 3'd2, 2'b10, d);
    check("R6 high word read", {16'h0, d}, 32'hFFFF);
  endtask

  task automatic t_bad_size;
    logic [15:0] d;
    do_wr(0, 3'd1, 2'b00, 16'h4242);
    do_wr(0, 3'd1, 2'b11, 16'h4343);
    do_wr(1, 3'd1, 2'b11, 16'h4444);
    do_rd(0, 3'd1, 2'b01, d);
    check("R11 page kept", {16'h0, d}, {24'h0, m_pg[1]});
    do_rd(1, 3'd1, 2'b01, d);
    check("R11 high page kept", {16'h0, d}, {24'h0, m_hp[1]});
    do_rd(0, 3'd1, 2'b00, d);
    check("R11 size 00 read", {16'h0, d}, 32'hFFFF);
    do_rd(0, 3'd1, 2'b11, d);
    check("R11 size 11 read", {16'h0, d}, 32'hFFFF);
  endtask

  task automatic t_address;
    logic [31:0] exp;
    for (int i = 0; i < 8; i++) begin
      pg_byte(i, 8'h21 + 8'(i * 2));
      hp_byte(i, 8'h80 + 8'(i));
    end
    pg_byte(7, 8'h47);
    for (int c = 0; c < 4; c++) begin
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        ch_sel = 2'(c); wide_mode = w[0]; cur_addr = 16'hF0A3 ^ 16'(c * 16'h0111);
        #1;
        if (w == 0)
          exp = m_hp[chan_map[c]] * 32'h0100_0000 + m_pg[chan_map[c]] * 32'h1_0000 + cur_addr;
        else
          exp = m_hp[chan_map[c]] * 32'h0100_0000 + (m_pg[chan_map[c]] & 8'hFE) * 32'h1_0000
                + cur_addr * 2;
        check(w == 0 ? "R7 R8 narrow address" : "R7 R9 wide address", xfer_addr, exp);
      end
    end
  endtask

  task automatic t_reset_keep;
    logic [15:0] d;
    do_rd(0, 3'd6, 2'b01, d);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R10 rdata cleared by reset", {16'h0, io_rdata}, 32'h0);
    rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      do_rd(0, 3'(i), 2'b01, d);
      check("R10 page kept over reset", {16'h0, d}, {24'h0, m_pg[i]});
      do_rd(1, 3'(i), 2'b01, d);
      check("R10 high page kept over reset", {16'h0, d}, {24'h0, m_hp[i]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_byte_access();
    t_word_access();
    t_high_page();
    t_bad_size();
    t_address();
    t_reset_keep();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule